// File: doc/BRIEF.md
# Multi-Tap Circular-Buffer Delay Line

This block turns one incoming word stream into several copies of itself, each shifted back in time by its own number of accepted words. Every word offered with the clock enable high, once the block is ready, goes into a circular store at the write pointer. Each output tap reads from an address that trails the write pointer by its delay. Both pointers wrap at the store depth, so the stream can run for any length of time. A tap's delay is either a build-time parameter or a value sampled from a per-tap delay input while the block reset is held.

The host first pulses the active-high block reset for at least three clocks. After the reset falls, the block clears its pointers and fill counters, waits through a fixed initialisation period, and then raises ready. From then on, each enabled cycle stores one word and advances every tap by one word. An active-low global reset puts the block in an idle state in which it is not ready, and it stays there until a block reset has been applied.

Top module: `tap_delay_line`

## Requirements
- R1: After the global reset, ready and every tap valid stay low, and enabled words are not stored, until a block reset pulse has been applied and the initialisation period has completed.
- R2: While the block reset is high, ready is low from the next clock on. Ready rises exactly INIT_CYCLES+1 clock edges after the first edge at which the block reset is sampled low.
- R3: A word is stored only on a cycle where both the clock enable and ready are high. Words offered while ready is low are dropped, so the first stored word is the first one offered with ready high.
- R4: Number the stored words k = 0, 1, … from the last block reset, and let a tap's delay be d. On the clock after word k is stored, that tap's data output equals stored word k−d and its valid bit is high when k ≥ d. When k < d, its valid bit is low.
- R5: On cycles with the clock enable low, every tap's data and valid hold their values. Delays are therefore counted in stored words, not in clocks.
- R6: A tap built as fixed uses its parameter delay and ignores its delay input. A variable tap takes its delay from its input slice, as sampled on the last cycle the block reset is high. Changes to the input after that have no effect until the next block reset.
- R7: A delay below MIN_DELAY is raised to MIN_DELAY. A delay above DEPTH is lowered to DEPTH.
- R8: The write and read pointers wrap modulo DEPTH. A delay equal to DEPTH is supported: on the cycle a slot is overwritten, that slot's old contents are read first.
- R9: A block reset applied while the block is running clears every tap valid and restarts word numbering at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Global asynchronous reset, active low |
| blkRst | input | 1 | Synchronous block reset, active high, held at least 3 clocks |
| clkEn | input | 1 | Marks a cycle that carries a valid source word |
| srcData | input | DATA_W | Source word |
| delayIn | input | NUM_TAPS*DLY_W | Delay per tap, tap t at bits [t*DLY_W +: DLY_W]; used by variable taps only |
| ready | output | 1 | High when the block accepts source words |
| tapData | output | NUM_TAPS*DATA_W | Delayed word per tap, tap t at bits [t*DATA_W +: DATA_W] |
| tapValid | output | NUM_TAPS | Per-tap flag, high once the tap has a delayed word |

## Verification
The bench builds the block with a 64-word store, a minimum delay of 8 and three taps. Tap 0 is fixed at 10, tap 1 is variable, and tap 2 is fixed at 64, which equals the depth. With a store this small, runs of about a hundred words wrap the pointers several times. Tap 2 reads each slot on the same cycle it is overwritten. The variable tap is driven below the minimum and above the depth, so both clamps are reached. A behavioural queue model predicts every tap on every clock and also covers gaps in the enable.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  typedef enum logic [1:0] {
    S_OFF  = 2'd0,
    S_RST  = 2'd1,
    S_INIT = 2'd2,
    S_RUN  = 2'd3
  } tdlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // zero pointers, fill counters and valids
    logic capture;  // load tap delays
    logic push;     // store one word and advance every tap
  } tdlCtl_t;

  function automatic int tdlClamp(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/tdl_ram.sv
module tdl_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int NRD    = 3,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    re,
  input  logic [NRD*ADDR_W-1:0]   rdAddr,
  output logic [NRD*DATA_W-1:0]   rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
  end

  // Read-first: a read of the slot being written returns the old word
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (re) rdData[p*DATA_W +: DATA_W] <= mem[rdAddr[p*ADDR_W +: ADDR_W]];
    end
  end

endmodule

// File: rtl/tdl_ctrl.sv
module tdl_ctrl
  import tdl_pkg::*;
#(
  parameter int INIT_CYCLES = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    blkRst,
  input  logic    clkEn,
  output tdlCtl_t ctl,
  output logic    ready
);

  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  tdlState_e       state, stateNext;
  logic [CNT_W-1:0] initCnt;

  always_comb begin
    stateNext = state;
    if (blkRst) begin
      stateNext = S_RST;
    end else begin
      unique case (state)
        S_OFF:  stateNext = S_OFF;
        S_RST:  stateNext = S_INIT;
        S_INIT: if (initCnt == CNT_W'(INIT_CYCLES - 1)) stateNext = S_RUN;
        S_RUN:  stateNext = S_RUN;
        default: stateNext = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_OFF;
      initCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == S_RST)       initCnt <= '0;
      else if (state == S_INIT) initCnt <= initCnt + 1'b1;
    end
  end

  assign ready       = (state == S_RUN);
  assign ctl.capture = blkRst;
  assign ctl.clear   = blkRst || (state != S_RUN);
  assign ctl.push    = clkEn && !blkRst && (state == S_RUN);

  // R2
  rst_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    blkRst |=> !ready);

  // R2
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(state) == S_INIT && $past(initCnt) == CNT_W'(INIT_CYCLES - 1)));

  // R1
  idle_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OFF && !blkRst) |=> !ready);

endmodule

// File: rtl/tdl_datapath.sv
module tdl_datapath
  import tdl_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 64,
  parameter int NUM_TAPS  = 3,
  parameter int DLY_W     = 8,
  parameter int MIN_DELAY = 8,
  parameter logic [NUM_TAPS*DLY_W-1:0] TAP_DELAY  = {8'd64, 8'd20, 8'd10},
  parameter logic [NUM_TAPS-1:0]       TAP_IS_VAR = 3'b010,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tdlCtl_t                      ctl,
  input  logic [DATA_W-1:0]            srcData,
  input  logic [NUM_TAPS*DLY_W-1:0]    delayIn,
  output logic [NUM_TAPS*DATA_W-1:0]   tapData,
  output logic [NUM_TAPS-1:0]          tapValid
);

  logic [ADDR_W-1:0]          wrPtr;
  logic [NUM_TAPS*ADDR_W-1:0] rdAddr;
  logic [CNT_W-1:0]           dly   [NUM_TAPS];
  logic [CNT_W-1:0]           fill  [NUM_TAPS];
  logic                       validQ[NUM_TAPS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (ctl.clear) begin
      wrPtr <= '0;
    end else if (ctl.push) begin
      wrPtr <= (wrPtr == ADDR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic [DLY_W-1:0] srcDly;
    int               clampedI;
    int               wpI;
    int               dI;

    if (TAP_IS_VAR[t]) begin : g_var
      assign srcDly = delayIn[t*DLY_W +: DLY_W];
    end else begin : g_fix
      logic [DLY_W-1:0] unusedIn;
      assign unusedIn = delayIn[t*DLY_W +: DLY_W];
      assign srcDly   = TAP_DELAY[t*DLY_W +: DLY_W];
    end

    assign clampedI = tdlClamp(int'(srcDly), MIN_DELAY, DEPTH);
    assign wpI      = int'(wrPtr);
    assign dI       = int'(dly[t]);
    assign rdAddr[t*ADDR_W +: ADDR_W] =
      ADDR_W'((wpI >= dI) ? (wpI - dI) : (wpI + DEPTH - dI));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dly[t] <= CNT_W'(MIN_DELAY);
      end else if (ctl.capture) begin
        dly[t] <= CNT_W'(clampedI);
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fill[t]   <= '0;
        validQ[t] <= 1'b0;
      end else if (ctl.clear) begin
        fill[t]   <= '0;
        validQ[t] <= 1'b0;
      end else if (ctl.push) begin
        validQ[t] <= (fill[t] == dly[t]);
        if (fill[t] != dly[t]) fill[t] <= fill[t] + 1'b1;
      end
    end

    assign tapValid[t] = validQ[t];

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      fill[t] <= dly[t]);

    // R7
    dly_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (int'(dly[t]) >= MIN_DELAY) && (int'(dly[t]) <= DEPTH));

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctl.push && !ctl.clear) |=> $stable(validQ[t]));

    // R9
    valid_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      ctl.clear |=> !validQ[t]);
  end

  tdl_ram #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .NRD    (NUM_TAPS)
  ) ram_i (
    .clk    (clk),
    .we     (ctl.push),
    .wrAddr (wrPtr),
    .wrData (srcData),
    .re     (ctl.push),
    .rdAddr (rdAddr),
    .rdData (tapData)
  );

  // R3
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.push && !ctl.clear) |=> $stable(wrPtr));

  // R8
  wp_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !ctl.clear && wrPtr == ADDR_W'(DEPTH - 1)) |=> (wrPtr == '0));

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line
  import tdl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 64,
  parameter int NUM_TAPS    = 3,
  parameter int DLY_W       = 8,
  parameter int MIN_DELAY   = 8,
  parameter int INIT_CYCLES = 12,
  parameter logic [NUM_TAPS*DLY_W-1:0] TAP_DELAY  = {8'd64, 8'd20, 8'd10},
  parameter logic [NUM_TAPS-1:0]       TAP_IS_VAR = 3'b010
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       blkRst,
  input  logic                       clkEn,
  input  logic [DATA_W-1:0]          srcData,
  input  logic [NUM_TAPS*DLY_W-1:0]  delayIn,
  output logic                       ready,
  output logic [NUM_TAPS*DATA_W-1:0] tapData,
  output logic [NUM_TAPS-1:0]        tapValid
);

  tdlCtl_t ctl;

  tdl_ctrl #(
    .INIT_CYCLES (INIT_CYCLES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .blkRst (blkRst),
    .clkEn  (clkEn),
    .ctl    (ctl),
    .ready  (ready)
  );

  tdl_datapath #(
    .DATA_W     (DATA_W),
    .DEPTH      (DEPTH),
    .NUM_TAPS   (NUM_TAPS),
    .DLY_W      (DLY_W),
    .MIN_DELAY  (MIN_DELAY),
    .TAP_DELAY  (TAP_DELAY),
    .TAP_IS_VAR (TAP_IS_VAR)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .srcData  (srcData),
    .delayIn  (delayIn),
    .tapData  (tapData),
    .tapValid (tapValid)
  );

endmodule

// File: tb/tap_delay_line_tb_top.sv
module tap_delay_line_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int DEP  = 64;
  localparam int NT   = 3;
  localparam int DLW  = 8;
  localparam int MIND = 8;
  localparam int INIT = 12;
  localparam logic [NT*DLW-1:0] TDLY = {8'd64, 8'd20, 8'd10};
  localparam logic [NT-1:0]     TVAR = 3'b010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkRst = 1'b0;
  logic clkEn = 1'b0;
  logic [DW-1:0]     srcData = '0;
  logic [NT*DLW-1:0] delayIn = '0;
  logic              ready;
  logic [NT*DW-1:0]  tapData;
  logic [NT-1:0]     tapValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_delay_line #(
    .DATA_W (DW), .DEPTH (DEP), .NUM_TAPS (NT), .DLY_W (DLW),
    .MIN_DELAY (MIND), .INIT_CYCLES (INIT),
    .TAP_DELAY (TDLY), .TAP_IS_VAR (TVAR)
  ) dut_i (
    .clk (clk), .rstN (rstN), .blkRst (blkRst), .clkEn (clkEn),
    .srcData (srcData), .delayIn (delayIn), .ready (ready),
    .tapData (tapData), .tapValid (tapValid)
  );

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;
  string phase = "R4";

  // reference model
  int hist[$];
  int kCnt = 0;
  bit readyM = 0;
  bit expV[NT];
  int expD[NT];
  int dlyM[NT];

  function automatic int clampI(int v);
    if (v < MIND) return MIND;
    if (v > DEP) return DEP;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(ready == readyM, phase, int'(ready), int'(readyM));
    for (int i = 0; i < NT; i++) begin
      check(tapValid[i] == expV[i], phase, int'(tapValid[i]), int'(expV[i]));
      if (expV[i] && tapValid[i])
        check(int'(tapData[i*DW +: DW]) == expD[i], phase,
              int'(tapData[i*DW +: DW]), expD[i]);
    end
  endtask

  // One clock with given enable and data; model updated after the edge
  task automatic step(bit e, int d);
    srcData = DW'(d);
    clkEn   = e;
    @(posedge clk);
    if (e && readyM) begin
      for (int i = 0; i < NT; i++) begin
        if (kCnt >= dlyM[i]) begin
          expV[i] = 1'b1;
          expD[i] = hist[kCnt - dlyM[i]];
        end else begin
          expV[i] = 1'b0;
        end
      end
      hist.push_back(d & 16'hFFFF);
      kCnt++;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic blockReset(int varDly);
    int n;
    delayIn = {8'd5, DLW'(varDly), 8'd30};  // fixed taps' slices must be ignored (R6)
    clkEn   = 1'b0;
    blkRst  = 1'b1;
    repeat (4) @(negedge clk);
    blkRst = 1'b0;
    readyM = 0;
    hist.delete();
    kCnt = 0;
    for (int i = 0; i < NT; i++) expV[i] = 1'b0;
    dlyM[0] = clampI(int'(TDLY[0*DLW +: DLW]));
    dlyM[1] = clampI(varDly);
    dlyM[2] = clampI(int'(TDLY[2*DLW +: DLW]));
    n = 0;
    // words offered before ready must be dropped (R3)
    clkEn   = 1'b1;
    srcData = 16'hBEEF;
    while (!ready && n < 40) begin
      @(negedge clk);
      n++;
      check(tapValid == '0, "R9", int'(tapValid), 0);
    end
    check(n == INIT + 1, "R2", n, INIT + 1);
    readyM = 1;
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin expV[i] = 0; expD[i] = 0; dlyM[i] = MIND; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: not ready and no valid before any block reset, enabled words ignored
    for (int c = 0; c < 6; c++) begin
      clkEn = 1'b1; srcData = DW'(c);
      @(negedge clk);
      check(ready == 1'b0, "R1", int'(ready), 0);
      check(tapValid == '0, "R1", int'(tapValid), 0);
    end

    // variable tap at 20; mixed gaps in enable; wraps several times
    blockReset(20);
    phase = "R3/R4";
    for (int c = 0; c < 30; c++) step(1'b1, 1000 + c);
    phase = "R5";
    for (int c = 0; c < 60; c++) step((c % 5) != 3, 2000 + 7*c);
    phase = "R6";
    delayIn[1*DLW +: DLW] = 8'd9;   // must not change tap 1
    delayIn[0*DLW +: DLW] = 8'd12;  // fixed tap, must not change
    for (int c = 0; c < 40; c++) step(1'b1, 3000 + 3*c);
    phase = "R8";
    for (int c = 0; c < 120; c++) step(1'b1, 4000 + 11*c);

    // clamp low, applied while running (R9 covered inside blockReset)
    blockReset(3);
    phase = "R7";
    for (int c = 0; c < 40; c++) step((c % 7) != 2, 5000 + c);

    // clamp high to DEPTH
    blockReset(200);
    phase = "R7";
    for (int c = 0; c < 150; c++) step(1'b1, 6000 + 13*c);

    // exact minimum and exact maximum on the variable tap
    blockReset(MIND);
    phase = "R4";
    for (int c = 0; c < 30; c++) step(1'b1, 7000 + 5*c);
    blockReset(DEP);
    phase = "R8";
    for (int c = 0; c < 140; c++) step((c % 9) != 4, 8000 + 17*c);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL all: watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule